// File: doc/BRIEF.md
# Dual Synchronous Clock Divider

This block derives two related clock waveforms from one fast input clock. The fast clock `clk` runs at twice the master rate. An internal master phase toggles on every `clk` edge, so the master clock is `clk`/2. All divisor figures below are given in `clk` cycles, so a divide by 1 of the master clock is a waveform with a period of 2 `clk` cycles. Each output is therefore a registered level, and no output is a gated copy of `clk`.

The reference output is either the master clock or a power-of-two prescaled copy of it, chosen by a select input. The main output passes through a second power-of-two prescaler. That prescaler feeds a programmable counter divider whose effective divisor is its code plus two. A bypass input can remove the divider from the path.

Setting inputs may change at any time, for example from a register file. Each path picks up new settings only on the edge that ends one of its own output periods. A period is therefore never cut short or stretched part way through. Every period starts low and ends high, so both output levels are low at each reload point.

Top module: `dual_clk_divider`

## Requirements
- R1: With the reference select at 1 and reference code k (2 bits: 00, 01, 10, 11 select ratios 1, 2, 4, 8), `ref_clk_o` has a period of 2·2^k `clk` cycles. It is low for the first 2^k cycles of each period and high for the last 2^k.
- R2: With the reference select at 0, `ref_clk_o` is the master clock. It toggles on every `clk` edge and is low in the first cycle after reset.
- R3: With bypass at 0, main code p (same 2-bit ratio coding as R1) and divider code n (10 bits), `main_clk_o` has a period of 2·2^p·(n+2) `clk` cycles. Code 0 gives a divisor of 2, and all ones gives 1025.
- R4: With bypass at 0, `main_clk_o` is high for the last 2·2^p·floor((n+2)/2) cycles of each period and low before that. An odd divisor therefore gives the shorter phase to the high level.
- R5: With bypass at 1, `main_clk_o` has a period of 2·2^p cycles with equal low and high halves, and the divider code has no effect on it.
- R6: The main code, divider code and bypass are sampled only on the edge that ends a `main_clk_o` period. Changes at any other time leave the current period unchanged.
- R7: The reference code and select are sampled only on the edge that ends a reference prescaler period (2·2^k cycles, with k the code in force). Changes at any other time leave `ref_clk_o` unchanged.
- R8: While `rst` is 1 at a clock edge, both outputs are low after that edge. The settings in force return to select 0, both codes 0, divider code 0 and bypass 0. These settings govern the first period after reset whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the master rate |
| rst | input | 1 | Synchronous reset, active high |
| ref_code_i | input | 2 | Reference prescaler ratio code |
| ref_sel_i | input | 1 | Reference source: 0 master clock, 1 prescaled |
| main_code_i | input | 2 | Main prescaler ratio code |
| div_code_i | input | 10 | Divider code, effective divisor is code + 2 |
| div_bypass_i | input | 1 | 1 removes the divider from the main path |
| ref_clk_o | output | 1 | Reference output waveform |
| main_clk_o | output | 1 | Main output waveform |

## Verification
Both outputs come from registers, so a level is due in the same cycle as the `clk` edge that produces it, with no added latency. A new setting is due at the first period-ending edge after it is applied, which may be many cycles later. The bench holds a period-and-phase model that pushes one expected pair of levels on every rising edge. A monitor pops that pair at the following falling edge and compares it with the outputs. Inputs change 1 ns after a rising edge, so each edge samples settled values, and settings applied in the middle of a period are reconciled by the model at the next boundary.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  // ratio selected by a prescaler code: 2**code
  function automatic int pre_ratio(input int code);
    return 1 << code;
  endfunction

  // effective divisor of the counter divider: code + 2
  function automatic int eff_div(input int code);
    return code + 2;
  endfunction

  // number of divider steps spent high (the shorter half on odd divisors)
  function automatic int high_steps(input int divisor);
    return divisor / 2;
  endfunction

  // number of divider steps spent low, i.e. the step index where the level rises
  function automatic int low_steps(input int divisor);
    return divisor - high_steps(divisor);
  endfunction

endpackage

// File: rtl/dcd_prescaler.sv
module dcd_prescaler
  import dcd_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic              take_i,
  output logic              wrap_o,
  output logic              lvl_o
);

  localparam int MAX_SHIFT = (1 << CODE_W) - 1;
  localparam int CNT_W     = MAX_SHIFT + 1;

  logic [CODE_W-1:0] act_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_n;
  logic [CNT_W-1:0]  half_w;
  logic [CNT_W-1:0]  last_w;
  logic              lvl_q;
  logic              wrap_w;

  // period is 2*ratio clk cycles, low half first
  always_comb begin
    half_w = CNT_W'(pre_ratio(int'(act_q)));
    last_w = CNT_W'(2 * pre_ratio(int'(act_q)) - 1);
    wrap_w = (cnt_q == last_w);
    cnt_n  = wrap_w ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      lvl_q <= (cnt_n >= half_w);
      if (wrap_w && take_i) begin
        act_q <= code_i;
      end
    end
  end

  assign wrap_o = wrap_w;
  assign lvl_o  = lvl_q;

  // R1: the level rises exactly at the midpoint of a period
  assert_rise_mid_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_q) |-> (cnt_q == half_w));

  // R1: the level falls only when the previous cycle closed a period
  assert_fall_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(lvl_q) |-> $past(wrap_w));

endmodule

// File: rtl/dcd_divider.sv
module dcd_divider
  import dcd_pkg::*;
#(
  parameter int N_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_i,
  input  logic [N_W-1:0] code_i,
  input  logic           bypass_i,
  input  logic           pre_lvl_i,
  output logic           term_o,
  output logic           out_o
);

  localparam int CNT_W = N_W + 1;

  logic [N_W-1:0]   act_code_q;
  logic             byp_q;
  logic [CNT_W-1:0] dc_q;
  logic [CNT_W-1:0] dc_inc;
  logic [CNT_W-1:0] d_w;
  logic [CNT_W-1:0] rise_w;
  logic             lvl_q;
  logic             term_w;

  always_comb begin
    d_w    = CNT_W'(eff_div(int'(act_code_q)));
    rise_w = CNT_W'(low_steps(int'(d_w)));
    dc_inc = dc_q + CNT_W'(1);
    term_w = step_i && (byp_q || (dc_q == d_w - CNT_W'(1)));
  end

  // all main-path settings are captured only at the terminal step
  always_ff @(posedge clk) begin
    if (rst) begin
      act_code_q <= '0;
      byp_q      <= 1'b0;
      dc_q       <= '0;
      lvl_q      <= 1'b0;
    end else if (term_w) begin
      act_code_q <= code_i;
      byp_q      <= bypass_i;
      dc_q       <= '0;
      lvl_q      <= 1'b0;
    end else if (step_i) begin
      dc_q  <= dc_inc;
      lvl_q <= (dc_inc >= rise_w);
    end
  end

  // both mux inputs are low right after a terminal edge, so the switch is clean
  assign out_o  = byp_q ? pre_lvl_i : lvl_q;
  assign term_o = term_w;

  // R3: the step count never leaves the range of the divisor in force
  assert_dc_range_R3: assert property (@(posedge clk) disable iff (rst)
    dc_q < d_w);

  // R4: once high, the divided level stays high until the terminal step
  assert_hold_high_R4: assert property (@(posedge clk) disable iff (rst)
    (lvl_q && !term_w) |=> lvl_q);

  // R6: the main output falls only at a terminal edge
  assert_fall_term_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(out_o) |-> $past(term_w));

  // R6: settings in force change only at a terminal edge
  assert_reload_term_R6: assert property (@(posedge clk) disable iff (rst)
    (act_code_q != $past(act_code_q) || byp_q != $past(byp_q)) |-> $past(term_w));

endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider
  import dcd_pkg::*;
#(
  parameter int PRE_W = 2,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] ref_code_i,
  input  logic             ref_sel_i,
  input  logic [PRE_W-1:0] main_code_i,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic             div_bypass_i,
  output logic             ref_clk_o,
  output logic             main_clk_o
);

  localparam int N_PATHS  = 2;
  localparam int REF_IDX  = 0;
  localparam int MAIN_IDX = 1;

  logic             mphase_q;
  logic             sel_q;
  logic             main_term;
  logic [PRE_W-1:0] pcode [N_PATHS];
  logic             ptake [N_PATHS];
  logic             pwrap [N_PATHS];
  logic             plvl  [N_PATHS];
  logic             ref_wrap;

  // master clock is half the fast clock
  always_ff @(posedge clk) begin
    if (rst) mphase_q <= 1'b0;
    else     mphase_q <= ~mphase_q;
  end

  always_comb begin
    pcode[REF_IDX]  = ref_code_i;
    pcode[MAIN_IDX] = main_code_i;
    ptake[REF_IDX]  = 1'b1;
    ptake[MAIN_IDX] = main_term;
  end

  for (genvar g = 0; g < N_PATHS; g++) begin : g_pre
    dcd_prescaler #(.CODE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .code_i (pcode[g]),
      .take_i (ptake[g]),
      .wrap_o (pwrap[g]),
      .lvl_o  (plvl[g])
    );
  end

  assign ref_wrap = pwrap[REF_IDX];

  // reference source select changes only at a reference period boundary
  always_ff @(posedge clk) begin
    if (rst)           sel_q <= 1'b0;
    else if (ref_wrap) sel_q <= ref_sel_i;
  end

  assign ref_clk_o = sel_q ? plvl[REF_IDX] : mphase_q;

  dcd_divider #(.N_W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .step_i    (pwrap[MAIN_IDX]),
    .code_i    (div_code_i),
    .bypass_i  (div_bypass_i),
    .pre_lvl_i (plvl[MAIN_IDX]),
    .term_o    (main_term),
    .out_o     (main_clk_o)
  );

  // R2: with the master clock selected the reference output toggles every cycle
  assert_master_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && !ref_wrap) |=> (ref_clk_o != $past(ref_clk_o)));

  // R7: the reference source changes only after a reference boundary
  assert_sel_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_q != $past(sel_q)) |-> $past(ref_wrap));

  // R8: a reset edge leaves both outputs low
  assert_reset_low_R8: assert property (@(posedge clk)
    rst |=> (!ref_clk_o && !main_clk_o));

endmodule

// File: tb/sim_dual_clk_divider.sv
`timescale 1ns/1ps
module sim_dual_clk_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ref_code = 2'd0;
  logic       ref_sel = 1'b0;
  logic [1:0] main_code = 2'd0;
  logic [9:0] div_code = 10'd0;
  logic       div_byp = 1'b0;
  logic       ref_clk;
  logic       main_clk;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    mon_on = 1'b0;
  string cur_tag = "R8";
  bit    exp_q [$];

  always #2.5 clk = ~clk;

  dual_clk_divider u0 (
    .clk          (clk),
    .rst          (rst),
    .ref_code_i   (ref_code),
    .ref_sel_i    (ref_sel),
    .main_code_i  (main_code),
    .div_code_i   (div_code),
    .div_bypass_i (div_byp),
    .ref_clk_o    (ref_clk),
    .main_clk_o   (main_clk)
  );

  // period/phase model: position in the current period, settings latched at its end
  int rpos = 0, rP = 1, mpos = 0, mP = 1, mD = 2;
  bit rsel = 0, mp = 0, mB = 0;

  function automatic int main_len(int p, int d, bit b);
    return b ? 2 * p : 2 * p * d;
  endfunction

  function automatic int main_hi(int p, int d, bit b);
    return b ? p : 2 * p * (d / 2);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rpos = 0; rP = 1; rsel = 0; mp = 0;
      mpos = 0; mP = 1; mD = 2; mB = 0;
    end else begin
      mp = ~mp;
      if (rpos == 2 * rP - 1) begin
        rpos = 0; rP = 1 << ref_code; rsel = ref_sel;
      end else begin
        rpos++;
      end
      if (mpos == main_len(mP, mD, mB) - 1) begin
        mpos = 0; mP = 1 << main_code; mD = int'(div_code) + 2; mB = div_byp;
      end else begin
        mpos++;
      end
    end
    exp_q.push_back(rsel ? (rpos >= rP) : mp);
    exp_q.push_back(mpos >= main_len(mP, mD, mB) - main_hi(mP, mD, mB));
  end

  // monitor: pop the expected pair and compare away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      string tag;
      bit    er, em;
      tag = rst ? "R8" : cur_tag;
      if (exp_q.size() < 2) begin
        n_checks++; n_errors++;
        $display("FAIL %s scoreboard empty: actual size %0d expected 2", tag, exp_q.size());
      end else begin
        er = exp_q.pop_front();
        em = exp_q.pop_front();
        n_checks++;
        if (ref_clk !== er) begin
          n_errors++;
          $display("FAIL %s ref_clk_o at %0t: actual %b expected %b", tag, $time, ref_clk, er);
        end
        n_checks++;
        if (main_clk !== em) begin
          n_errors++;
          $display("FAIL %s main_clk_o at %0t: actual %b expected %b", tag, $time, main_clk, em);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    // R8: inputs differ from the defaults while in reset
    ref_code = 2'd3; ref_sel = 1'b1; main_code = 2'd3; div_code = 10'd5;
    @(posedge clk); #1;
    mon_on = 1'b1;
    step(3);
    rst = 1'b0;
    cur_tag = "R8";
    step(4);
    // R1 and R3: prescaled reference by 8, main 8 x 7
    cur_tag = "R1_R3";
    step(240);
    // R4: odd divisor 3, reference by 2
    ref_code = 2'd1; main_code = 2'd0; div_code = 10'd1;
    cur_tag = "R4";
    step(150);
    // R2: master clock on the reference output
    ref_sel = 1'b0;
    cur_tag = "R2";
    step(60);
    // R4: largest divisor 1025
    div_code = 10'h3FF;
    cur_tag = "R4";
    step(2200);
    // R5: bypass with the divider code moving underneath
    div_byp = 1'b1; main_code = 2'd2;
    cur_tag = "R5";
    step(30);
    div_code = 10'd7;
    step(30);
    div_code = 10'd300;
    step(30);
    main_code = 2'd1;
    step(40);
    // R6: main settings churn in the middle of periods
    div_byp = 1'b0; main_code = 2'd0; div_code = 10'd10;
    cur_tag = "R6";
    step(30);
    for (int i = 0; i < 40; i++) begin
      div_code  = 10'((i * 37) % 50);
      main_code = 2'(i % 3);
      div_byp   = (i % 5 == 4);
      step(i % 7 + 3);
    end
    step(400);
    // R7: reference settings churn in the middle of periods
    cur_tag = "R7";
    for (int i = 0; i < 40; i++) begin
      ref_code = 2'((i * 3) % 4);
      ref_sel  = (i % 3 != 0);
      step(i % 5 + 1);
    end
    step(60);
    // R8: reset in the middle of a run
    div_code = 10'd4; main_code = 2'd1; ref_sel = 1'b1; ref_code = 2'd2;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    cur_tag = "R8";
    step(100);
    mon_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule